// File: doc/BRIEF.md
# Latched-Output Serial Shift Register

This block converts a serial bit stream into a parallel word. A chain of shift stages takes one bit per rising edge of a shift clock. A separate storage clock copies the whole chain at once into a holding register, and that register drives the parallel outputs. Because the holding register has its own clock, the outputs stay steady while the next word is being shifted in.

The last shift stage is brought out as a serial output, so that further blocks can be chained behind this one. The chain length is a whole number of 8-bit units, set by the `UNITS` parameter, with `W = 8*UNITS` bits in total.

An active-low clear empties the shift stages at once and leaves the holding register alone. A separate active-low power-on reset zeroes both. An active-low output enable gates the parallel lines only. Each parallel line is delivered as a data bit plus an active-high drive bit, so a pad ring can build the tri-state output outside this block.

Top module: `shreg_latch_top`

## Requirements
- R1: On each rising edge of `shift_clk`, while both resets are high, `ser_in` is taken into stage 0 and stage k moves to stage k+1, for every k from 0 to W-2.
- R2: `ser_out` always shows stage W-1, so after a shift it equals what stage W-2 held before that edge.
- R3: On each rising edge of `store_clk`, all W shift stages are copied into the holding register in one step.
- R4: While `clr_n` is low, the shift stages are zero without waiting for any clock edge, `ser_out` reads 0, and shift edges have no effect.
- R5: `clr_n` does not alter the holding register, so the parallel outputs keep their value while the clear is held.
- R6: A `store_clk` edge that arrives while `clr_n` is low loads all zeros into the holding register.
- R7: When `shift_clk` and `store_clk` rise together, the holding register takes the stage contents from before that shift.
- R8: With `oe_n` = 0, `par_drive` is all ones and `par_data` equals the holding register. With `oe_n` = 1, `par_drive` is all zeros and `par_data` reads all zeros.
- R9: Toggling `oe_n` changes neither the shift stages nor the holding register.
- R10: Parallel line n carries holding bit n, which was copied from stage n. After W shifts, the first bit shifted in appears on line W-1 and the last one on line 0.
- R11: While `por_n` is low, both the shift stages and the holding register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; the chain advances on its rising edge |
| store_clk | input | 1 | Storage clock; the holding register loads on its rising edge |
| por_n | input | 1 | Active-low power-on reset for all state |
| clr_n | input | 1 | Active-low asynchronous clear of the shift stages only |
| ser_in | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Active-low parallel output enable |
| par_data | output | W | Parallel data, forced to zero when not driven |
| par_drive | output | W | Per-line active-high drive enable |
| ser_out | output | 1 | Cascade output from stage W-1 |

## Verification
The assertions are sampled on the two clock edges. They assume that `clr_n`, `por_n`, `oe_n` and `ser_in` never change at the same instant as a clock edge, and that reset is released while both clocks are low. The stimulus therefore changes data and control inputs one time step after a reference edge, raises the clocks one step after that, and lowers them just after the opposite reference edge. The checks on R4 and R6 rely on the clear being held across whole storage edges; the bench keeps it low across several complete clock pulses.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    // width of one chainable unit
    localparam int UNIT_BITS = 8;
endpackage

// File: rtl/shreg_unit.sv
module shreg_unit #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    output logic [BITS-1:0] q,
    output logic            dout
);
    // stage 0 takes din; stage k feeds stage k+1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[BITS-2:0], din};
    end

    assign dout = q[BITS-1];
endmodule

// File: rtl/shreg_hold.sv
module shreg_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/shreg_out_gate.sv
module shreg_out_gate #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] hold,
    output logic [W-1:0] par_data,
    output logic [W-1:0] par_drive
);
    always_comb begin
        par_drive = {W{~oe_n}};
        par_data  = oe_n ? '0 : hold;
    end
endmodule

// File: rtl/shreg_latch_top.sv
module shreg_latch_top #(
    parameter int UNITS = 2,
    localparam int UB   = shreg_pkg::UNIT_BITS,
    localparam int W    = UNITS * UB
) (
    input  logic         shift_clk,
    input  logic         store_clk,
    input  logic         por_n,
    input  logic         clr_n,
    input  logic         ser_in,
    input  logic         oe_n,
    output logic [W-1:0] par_data,
    output logic [W-1:0] par_drive,
    output logic         ser_out
);
    logic [W-1:0]   stages;
    logic [W-1:0]   store_q;
    logic [UNITS:0] link;
    logic           shift_rst_n;

    assign shift_rst_n = clr_n & por_n;
    assign link[0]     = ser_in;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        shreg_unit #(.BITS(UB)) u_unit (
            .clk   (shift_clk),
            .rst_n (shift_rst_n),
            .din   (link[u]),
            .q     (stages[u*UB +: UB]),
            .dout  (link[u+1])
        );
    end

    assign ser_out = link[UNITS];

    shreg_hold #(.W(W)) u_hold (
        .clk   (store_clk),
        .por_n (por_n),
        .d     (stages),
        .q     (store_q)
    );

    shreg_out_gate #(.W(W)) u_gate (
        .oe_n      (oe_n),
        .hold      (store_q),
        .par_data  (par_data),
        .par_drive (par_drive)
    );
endmodule

// File: rtl/shreg_latch_chk.sv
module shreg_latch_chk #(
    parameter int UNITS = 2,
    localparam int W    = UNITS * shreg_pkg::UNIT_BITS
) (
    input logic         shift_clk,
    input logic         store_clk,
    input logic         por_n,
    input logic         clr_n,
    input logic         oe_n,
    input logic         ser_out,
    input logic [W-1:0] par_data,
    input logic [W-1:0] par_drive,
    input logic [W-1:0] stages,
    input logic [W-1:0] store_q
);
    logic sh_rst_n;
    logic sh_armed;
    logic st_armed;

    assign sh_rst_n = clr_n & por_n;

    // set once a shift edge has passed with no reset since
    always_ff @(posedge shift_clk or negedge sh_rst_n) begin
        if (!sh_rst_n) sh_armed <= 1'b0;
        else           sh_armed <= 1'b1;
    end

    always_ff @(posedge store_clk or negedge por_n) begin
        if (!por_n) st_armed <= 1'b0;
        else        st_armed <= 1'b1;
    end

    assert_stage_move_R1: assert property (@(posedge shift_clk) disable iff (!sh_rst_n)
        sh_armed |-> (stages[W-1:1] == $past(stages[W-2:0])));

    assert_cascade_out_R2: assert property (@(posedge shift_clk) disable iff (!sh_rst_n)
        sh_armed |-> (ser_out == $past(stages[W-2])));

    assert_parallel_copy_R3: assert property (@(posedge store_clk) disable iff (!por_n)
        st_armed |-> (store_q == $past(stages)));

    assert_clear_empties_R4: assert property (@(posedge store_clk) disable iff (!por_n)
        !clr_n |-> (ser_out == 1'b0 && stages == '0));

    assert_store_in_clear_R6: assert property (@(posedge store_clk) disable iff (!por_n)
        (st_armed && $past(!clr_n)) |-> (store_q == '0));

    assert_gate_on_R8: assert property (@(posedge store_clk) disable iff (!por_n)
        !oe_n |-> (par_drive == {W{1'b1}} && par_data == store_q));

    assert_gate_off_R8: assert property (@(posedge store_clk) disable iff (!por_n)
        oe_n |-> (par_drive == '0 && par_data == '0));
endmodule

bind shreg_latch_top shreg_latch_chk #(.UNITS(UNITS)) u_chk (
    .shift_clk (shift_clk),
    .store_clk (store_clk),
    .por_n     (por_n),
    .clr_n     (clr_n),
    .oe_n      (oe_n),
    .ser_out   (ser_out),
    .par_data  (par_data),
    .par_drive (par_drive),
    .stages    (stages),
    .store_q   (store_q)
);

// File: tb/test_shreg_latch_top.sv
module test_shreg_latch_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNITS      = 2;
    localparam int W          = UNITS * 8;

    typedef struct {
        logic         ser;
        logic [W-1:0] data;
        logic [W-1:0] drive;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic shift_clk = 1'b0, store_clk = 1'b0;
    logic por_n = 1'b0, clr_n = 1'b1, ser_in = 1'b0, oe_n = 1'b0;
    logic [W-1:0] par_data, par_drive;
    logic ser_out;

    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_st = '0;
    exp_t exp_q[$];
    exp_t cur;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shreg_latch_top #(.UNITS(UNITS)) i_shreg_latch_top (
        .shift_clk (shift_clk),
        .store_clk (store_clk),
        .por_n     (por_n),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .oe_n      (oe_n),
        .par_data  (par_data),
        .par_drive (par_drive),
        .ser_out   (ser_out)
    );

    // driver side: compute expectation from the requirement model
    task automatic push(input string tag);
        exp_t e;
        e.ser   = m_sr[W-1];
        e.data  = oe_n ? '0 : m_st;
        e.drive = oe_n ? '0 : {W{1'b1}};
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse(input bit sh, input bit st, input logic b, input string tag);
        @(posedge clk);
        #1 ser_in = b;
        #1;
        if (st) begin
            store_clk = 1'b1;
            m_st = (clr_n && por_n) ? m_sr : '0;
        end
        if (sh) begin
            shift_clk = 1'b1;
            if (clr_n && por_n) m_sr = {m_sr[W-2:0], b};
        end
        push(tag);
        @(negedge clk);
        #1 shift_clk = 1'b0;
        store_clk = 1'b0;
    endtask

    task automatic set_ctl(input logic p, input logic c, input logic o, input string tag);
        @(posedge clk);
        #1 por_n = p;
        clr_n = c;
        oe_n  = o;
        if (!p) begin m_sr = '0; m_st = '0; end
        if (!c) m_sr = '0;
        push(tag);
    endtask

    // monitor side
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (ser_out !== cur.ser || par_data !== cur.data || par_drive !== cur.drive) begin
                errors++;
                $display("FAIL %s: got ser=%b data=%h drive=%h, expected ser=%b data=%h drive=%h",
                         cur.tag, ser_out, par_data, par_drive, cur.ser, cur.data, cur.drive);
            end
        end
    end

    initial begin
        logic [W-1:0] word_a = 16'hA5C3;
        logic [W-1:0] word_b = 16'h0F1E;
        set_ctl(1'b0, 1'b1, 1'b0, "R11 reset state");
        set_ctl(1'b1, 1'b1, 1'b0, "R11 release");
        // first bit in ends on line W-1
        for (int i = W-1; i >= 0; i--) pulse(1'b1, 1'b0, word_a[i], "R1 R2 shift");
        pulse(1'b0, 1'b1, 1'b0, "R3 R10 store word A");
        set_ctl(1'b1, 1'b1, 1'b1, "R8 outputs off");
        for (int i = W-1; i >= 0; i--) pulse(1'b1, 1'b0, word_b[i], "R1 R9 shift while off");
        set_ctl(1'b1, 1'b1, 1'b0, "R9 re-enable keeps word A");
        set_ctl(1'b1, 1'b1, 1'b1, "R8 off again");
        set_ctl(1'b1, 1'b1, 1'b0, "R9 toggle keeps word A");
        pulse(1'b0, 1'b1, 1'b0, "R3 R10 store word B");
        set_ctl(1'b1, 1'b0, 1'b0, "R4 R5 clear held");
        pulse(1'b1, 1'b0, 1'b1, "R4 shift ignored in clear");
        pulse(1'b1, 1'b0, 1'b1, "R4 R5 second ignored shift");
        pulse(1'b0, 1'b1, 1'b0, "R6 store during clear");
        set_ctl(1'b1, 1'b1, 1'b0, "R4 clear released");
        for (int i = 0; i < 6; i++) pulse(1'b1, 1'b1, 1'(i % 3 == 0), "R7 tied clocks");
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b1, "R2 fill ones");
        pulse(1'b0, 1'b1, 1'b0, "R3 store ones");
        set_ctl(1'b0, 1'b1, 1'b0, "R11 power-on clears all");
        set_ctl(1'b1, 1'b1, 1'b0, "R11 after release");
        pulse(1'b1, 1'b0, 1'b1, "R1 R10 single one enters");
        for (int i = 0; i < W-1; i++) pulse(1'b1, 1'b0, 1'b0, "R2 walk to cascade");
        pulse(1'b0, 1'b1, 1'b0, "R10 one on top line");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule